// File: doc/BRIEF.md
# USB endpoint mode handshake controller

This block keeps the mode register of a single USB device endpoint and decides how the endpoint answers each token from the host. A packet engine gives it decoded token events: the token kind, whether the token was good, the start of a data phase, and the end of the transaction with a data-good flag and a byte count. A static direction input says whether the endpoint faces IN or OUT. The block answers every completed, recognised transaction with an ACK, NAK or STALL strobe and an interrupt pulse. It then rewrites the mode, records which token arrived, and captures the byte count.

A CPU reaches two 8-bit registers through a plain strobe port: the mode/status register and the count register. Any ACK sets a hardware write-lock. While the lock is set, CPU writes to the mode field, the IN/OUT status bits and the count are dropped. A CPU read of the mode register clears the lock. The SETUP status bit is outside the lock, so firmware can always clear it and hardware can always set it.

The inputs are single-cycle strobes with no ready signal. The block takes one event per cycle and never applies back-pressure. The packet engine is expected to sequence token, data start and end in separate cycles.

Top module: `usb_ep_mode_ctrl`

## Requirements
- R1: After reset, the mode register reads 0x00, the count reads 0, the lock is clear, and no handshake or interrupt is raised.
- R2: Mode 0000 (off) ignores every token. Only a CPU write takes the endpoint out of it.
- R3: Token codes are 01 OUT, 10 IN and 11 SETUP. A SETUP in mode 0001 or 0010 is answered with ACK (handshake code 00), and the mode becomes 0001. In mode 0011, every recognised token is answered with STALL (code 10).
- R4: IN tokens are ignored when the direction input is 0, and OUT tokens are ignored when it is 1. Mode 0001 NAKs (code 01) both IN and OUT. Mode 1000 NAKs OUT and mode 1100 NAKs IN. Mode 1001 and mode 1010 ACK OUT. Mode 1101 and mode 1110 ACK IN. Mode 0010 and all other encodings ignore IN and OUT.
- R5: After an ACK, mode 1001 becomes 1000 and mode 1101 becomes 1100: the low bit is cleared. Modes 1010 and 1110 keep their value.
- R6: There is no response, no interrupt and no register change in three cases: the token strobe had its good flag low, the end strobe had its data-good flag low, or an end strobe arrived with no good token pending.
- R7: The handshake strobe and the interrupt are single-cycle pulses. Both appear in the cycle after the end strobe.
- R8: An ACK sets the lock (lock output 1). While the lock is set, CPU writes to mode bits 6..0 and to the count are dropped. A CPU read of the mode register clears the lock. If an ACK and a read fall in the same cycle, the lock stays set.
- R9: Bit 7 of the mode register is the SETUP status bit. It is set on the data-phase strobe that follows a SETUP token accepted by mode 0001 or 0010, even while the lock is set. A CPU write to bit 7 takes effect whether or not the lock is set.
- R10: Bits 6 and 5 are the IN and OUT status bits, and mode sits in bits 3..0 with bit 4 reading 0. On each response, hardware sets bit 6 for an IN token and bit 5 for an OUT token, and clears the other bit.
- R11: On an ACKed OUT or SETUP, the count register loads the byte count from the end strobe. An ACKed IN leaves the count unchanged.
- R12: A CPU write in the same cycle as an end strobe is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1: endpoint faces IN, 0: faces OUT |
| tok_stb | input | 1 | Token received strobe |
| tok_pid | input | 2 | Token kind: 01 OUT, 10 IN, 11 SETUP |
| tok_ok | input | 1 | Token passed checks and addresses this endpoint |
| dat_stb | input | 1 | Start of the data phase |
| end_stb | input | 1 | End of the transaction |
| end_ok | input | 1 | Data or host handshake was good |
| end_cnt | input | CNT_W | Received byte count |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (a read of mode clears the lock) |
| cpu_sel | input | 1 | 0: mode register, 1: count register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register, combinational |
| hs_stb | output | 1 | Handshake decided |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| irq | output | 1 | Transaction-complete interrupt pulse |
| lock_o | output | 1 | CPU write-lock state |

## Verification
A wrong stored mode does not stay hidden. It reaches cpu_rdata in the same cycle it is stored, and the handshake code one cycle after the next end strobe. A lost or stuck lock first shows as a CPU write that lands or vanishes, and it is visible on lock_o at once. A pending-token register holding the wrong kind shows up as a wrong status bit and a wrong response one cycle after the end strobe. The same fault can also show a cycle after the data strobe, as a SETUP bit that is set or not set.

// File: rtl/ep_mode_pkg.sv
`timescale 1ns/1ps
package ep_mode_pkg;
  typedef enum logic [1:0] {
    PID_NONE  = 2'b00,
    PID_OUT   = 2'b01,
    PID_IN    = 2'b10,
    PID_SETUP = 2'b11
  } pid_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_NONE  = 2'b11
  } hs_e;

  localparam logic [3:0] M_OFF        = 4'b0000;
  localparam logic [3:0] M_NAK_IO     = 4'b0001;
  localparam logic [3:0] M_SETUP_ONLY = 4'b0010;
  localparam logic [3:0] M_STALL      = 4'b0011;
  localparam logic [3:0] M_NAK_OUT    = 4'b1000;
  localparam logic [3:0] M_ACK_OUT    = 4'b1001;
  localparam logic [3:0] M_HOLD_OUT   = 4'b1010;
  localparam logic [3:0] M_NAK_IN     = 4'b1100;
  localparam logic [3:0] M_ACK_IN     = 4'b1101;
  localparam logic [3:0] M_HOLD_IN    = 4'b1110;

  typedef struct packed {
    hs_e        hs;
    logic [3:0] nxt;
  } verdict_t;
endpackage

// File: rtl/ep_mode_dec.sv
`timescale 1ns/1ps
module ep_mode_dec
  import ep_mode_pkg::*;
(
  input  logic [3:0] mode,
  input  pid_e       pid,
  input  logic       dir_in,
  output verdict_t   verd,
  output logic       acc_setup
);
  always_comb begin
    acc_setup = (mode == M_NAK_IO) || (mode == M_SETUP_ONLY);
    verd.hs   = HS_NONE;
    verd.nxt  = mode;
    case (pid)
      PID_SETUP: begin
        if (acc_setup) begin
          verd.hs  = HS_ACK;
          verd.nxt = M_NAK_IO;
        end else if (mode == M_STALL) begin
          verd.hs = HS_STALL;
        end
      end
      PID_IN: begin
        if (dir_in) begin
          case (mode)
            M_NAK_IO, M_NAK_IN: verd.hs = HS_NAK;
            M_STALL:            verd.hs = HS_STALL;
            M_ACK_IN: begin
              verd.hs  = HS_ACK;
              verd.nxt = {mode[3:1], 1'b0};
            end
            M_HOLD_IN:          verd.hs = HS_ACK;
            default:            verd.hs = HS_NONE;
          endcase
        end
      end
      PID_OUT: begin
        if (!dir_in) begin
          case (mode)
            M_NAK_IO, M_NAK_OUT: verd.hs = HS_NAK;
            M_STALL:             verd.hs = HS_STALL;
            M_ACK_OUT: begin
              verd.hs  = HS_ACK;
              verd.nxt = {mode[3:1], 1'b0};
            end
            M_HOLD_OUT:          verd.hs = HS_ACK;
            default:             verd.hs = HS_NONE;
          endcase
        end
      end
      default: verd.hs = HS_NONE;
    endcase
  end
endmodule

// File: rtl/ep_tok_track.sv
`timescale 1ns/1ps
module ep_tok_track
  import ep_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_stb,
  input  logic [1:0] tok_pid,
  input  logic       tok_ok,
  input  logic       end_stb,
  output logic       pend_v,
  output pid_e       pend_pid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_pid <= PID_NONE;
    end else if (tok_stb) begin
      pend_v   <= tok_ok && (tok_pid != PID_NONE);
      pend_pid <= pid_e'(tok_pid);
    end else if (end_stb) begin
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_wr_lock.sv
`timescale 1ns/1ps
module ep_wr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_clr_i,
  input  logic wr_req_i,
  input  logic hw_busy_i,
  output logic lock_o,
  output logic wr_full_o,
  output logic wr_free_o
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (set_i)    lock_q <= 1'b1;
    else if (rd_clr_i) lock_q <= 1'b0;
  end

  assign lock_o    = lock_q;
  assign wr_free_o = wr_req_i && !hw_busy_i;
  assign wr_full_o = wr_free_o && !lock_q;
endmodule

// File: rtl/usb_ep_mode_ctrl.sv
`timescale 1ns/1ps
module usb_ep_mode_ctrl
  import ep_mode_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir_in,
  input  logic             tok_stb,
  input  logic [1:0]       tok_pid,
  input  logic             tok_ok,
  input  logic             dat_stb,
  input  logic             end_stb,
  input  logic             end_ok,
  input  logic [CNT_W-1:0] end_cnt,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             cpu_sel,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             hs_stb,
  output logic [1:0]       hs_code,
  output logic             irq,
  output logic             lock_o
);
  localparam int REG_W = 8;

  logic [3:0]       mode_q;
  logic             st_setup_q, st_in_q, st_out_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hs_stb_q, irq_q;
  hs_e              hs_code_q;

  logic     pend_v;
  pid_e     pend_pid;
  verdict_t verd;
  logic     acc_setup;
  logic     fin, resp, ack;
  logic     wr_full, wr_free;
  logic     setup_seen;

  ep_tok_track u_tok (
    .clk(clk), .rst_n(rst_n), .tok_stb(tok_stb), .tok_pid(tok_pid),
    .tok_ok(tok_ok), .end_stb(end_stb), .pend_v(pend_v), .pend_pid(pend_pid)
  );

  ep_mode_dec u_dec (
    .mode(mode_q), .pid(pend_pid), .dir_in(cfg_dir_in),
    .verd(verd), .acc_setup(acc_setup)
  );

  assign fin  = end_stb && end_ok && pend_v;
  assign resp = fin && (verd.hs != HS_NONE);
  assign ack  = resp && (verd.hs == HS_ACK);
  assign setup_seen = dat_stb && pend_v && (pend_pid == PID_SETUP) && acc_setup;

  ep_wr_lock u_lock (
    .clk(clk), .rst_n(rst_n), .set_i(ack),
    .rd_clr_i(cpu_rd && !cpu_sel), .wr_req_i(cpu_wr),
    .hw_busy_i(end_stb), .lock_o(lock_o),
    .wr_full_o(wr_full), .wr_free_o(wr_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_stb_q  <= 1'b0;
      irq_q     <= 1'b0;
      hs_code_q <= HS_NONE;
    end else begin
      hs_stb_q <= resp;
      irq_q    <= resp;
      if (resp) hs_code_q <= verd.hs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      st_in_q  <= 1'b0;
      st_out_q <= 1'b0;
      cnt_q    <= '0;
    end else if (resp) begin
      st_in_q  <= (pend_pid == PID_IN);
      st_out_q <= (pend_pid == PID_OUT);
      if (ack) begin
        mode_q <= verd.nxt;
        if (pend_pid != PID_IN) cnt_q <= end_cnt;
      end
    end else if (wr_full && !cpu_sel) begin
      mode_q   <= cpu_wdata[3:0];
      st_in_q  <= cpu_wdata[6];
      st_out_q <= cpu_wdata[5];
    end else if (wr_full && cpu_sel) begin
      cnt_q <= cpu_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     st_setup_q <= 1'b0;
    else if (setup_seen)            st_setup_q <= 1'b1;
    else if (wr_free && !cpu_sel)   st_setup_q <= cpu_wdata[7];
  end

  always_comb begin
    if (cpu_sel) cpu_rdata = REG_W'(cnt_q);
    else         cpu_rdata = {st_setup_q, st_in_q, st_out_q, 1'b0, mode_q};
  end

  assign hs_stb  = hs_stb_q;
  assign hs_code = hs_code_q;
  assign irq     = irq_q;
endmodule

// File: rtl/ep_mode_chk.sv
`timescale 1ns/1ps
module ep_mode_chk
  import ep_mode_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             end_stb,
  input logic             end_ok,
  input logic             dat_stb,
  input logic             cpu_wr,
  input logic             cpu_sel,
  input logic             hs_stb,
  input logic [1:0]       hs_code,
  input logic             lock_o,
  input logic [3:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             st_setup_q,
  input logic             pend_v,
  input logic [1:0]       pend_pid
);
  // R2: off mode only leaves through an accepted CPU write
  a_r2_off_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && !(cpu_wr && !cpu_sel && !lock_o && !end_stb)) |=> mode_q == M_OFF);

  // R3: good SETUP in a setup-taking mode is ACKed and lands in 0001
  a_r3_setup_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && end_ok && pend_v && pend_pid == PID_SETUP &&
     (mode_q == M_NAK_IO || mode_q == M_SETUP_ONLY))
    |=> (hs_stb && hs_code == HS_ACK && mode_q == M_NAK_IO));

  // R5: hold modes survive any end of transaction
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && (mode_q == M_HOLD_OUT || mode_q == M_HOLD_IN)) |=> $stable(mode_q));

  // R6, R7: a handshake needs a good end with a pending token one cycle before
  a_r6_resp_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stb |-> $past(end_stb && end_ok && pend_v));

  // R8: an ACK always leaves the lock set
  a_r8_lock_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_stb && hs_code == HS_ACK) |-> lock_o);

  // R8: count frozen while locked and no transaction ends
  a_r8_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !end_stb) |=> $stable(cnt_q));

  // R9: setup bit set by a qualifying data phase regardless of the lock
  a_r9_setup_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_stb && pend_v && pend_pid == PID_SETUP &&
     (mode_q == M_NAK_IO || mode_q == M_SETUP_ONLY)) |=> st_setup_q);
endmodule

bind usb_ep_mode_ctrl ep_mode_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .end_stb(end_stb), .end_ok(end_ok),
  .dat_stb(dat_stb), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
  .hs_stb(hs_stb), .hs_code(hs_code), .lock_o(lock_o),
  .mode_q(mode_q), .cnt_q(cnt_q), .st_setup_q(st_setup_q),
  .pend_v(pend_v), .pend_pid(pend_pid)
);

// File: tb/test_usb_ep_mode_ctrl.sv
`timescale 1ns/1ps
module test_usb_ep_mode_ctrl;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dir_in = 1'b0;
  logic tok_stb = 1'b0, tok_ok = 1'b0, dat_stb = 1'b0, end_stb = 1'b0, end_ok = 1'b0;
  logic [1:0] tok_pid = 2'b00;
  logic [CW-1:0] end_cnt = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic hs_stb, irq, lock_o;
  logic [1:0] hs_code;

  always #10 clk = ~clk;

  usb_ep_mode_ctrl #(.CNT_W(CW)) i_usb_ep_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
    .tok_stb(tok_stb), .tok_pid(tok_pid), .tok_ok(tok_ok),
    .dat_stb(dat_stb), .end_stb(end_stb), .end_ok(end_ok), .end_cnt(end_cnt),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hs_stb(hs_stb), .hs_code(hs_code),
    .irq(irq), .lock_o(lock_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode, m_cnt;
  bit m_set, m_in, m_out, m_lock, m_pv, m_hs, m_irq;
  int m_pid, m_code;

  function automatic void ref_decide(input int m, input int p, input bit din,
                                     output int r, output int nm);
    r = 3; nm = m;
    if (p == 3) begin
      if (m == 1 || m == 2) begin r = 0; nm = 1; end
      else if (m == 3) r = 2;
    end else if (p == 2 && din) begin
      if (m == 1 || m == 12) r = 1;
      else if (m == 3) r = 2;
      else if (m == 13) begin r = 0; nm = 12; end
      else if (m == 14) r = 0;
    end else if (p == 1 && !din) begin
      if (m == 1 || m == 8) r = 1;
      else if (m == 3) r = 2;
      else if (m == 9) begin r = 0; nm = 8; end
      else if (m == 10) r = 0;
    end
  endfunction

  task automatic ref_step();
    int r, nm;
    int o_mode; bit o_lock, o_pv; int o_pid;
    bit acked;
    o_mode = m_mode; o_lock = m_lock; o_pv = m_pv; o_pid = m_pid;
    acked = 1'b0; m_hs = 1'b0; m_irq = 1'b0;
    if (end_stb) begin
      if (o_pv && end_ok) begin
        ref_decide(o_mode, o_pid, cfg_dir_in, r, nm);
        if (r != 3) begin
          m_hs = 1'b1; m_irq = 1'b1; m_code = r;
          m_in = (o_pid == 2); m_out = (o_pid == 1);
          if (r == 0) begin
            acked = 1'b1; m_mode = nm; m_lock = 1'b1;
            if (o_pid != 2) m_cnt = int'(end_cnt);
          end
        end
      end
      m_pv = 1'b0;
    end else if (cpu_wr) begin
      if (!cpu_sel) begin
        m_set = cpu_wdata[7];
        if (!o_lock) begin
          m_mode = int'(cpu_wdata[3:0]); m_in = cpu_wdata[6]; m_out = cpu_wdata[5];
        end
      end else if (!o_lock) m_cnt = int'(cpu_wdata[CW-1:0]);
    end
    if (dat_stb && o_pv && o_pid == 3 && (o_mode == 1 || o_mode == 2)) m_set = 1'b1;
    if (tok_stb) begin
      m_pv = tok_ok && tok_pid != 2'b00; m_pid = int'(tok_pid);
    end
    if (cpu_rd && !cpu_sel && !acked) m_lock = 1'b0;
  endtask

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_set = 0; m_in = 0; m_out = 0; m_lock = 0;
      m_pv = 0; m_pid = 0; m_hs = 0; m_irq = 0; m_code = 3;
    end else ref_step();
    #5;
    cmp("hs_stb", int'(hs_stb), int'(m_hs));
    cmp("irq", int'(irq), int'(m_irq));
    cmp("lock", int'(lock_o), int'(m_lock));
    if (m_hs) cmp("hs_code", int'(hs_code), m_code);
    if (cpu_sel) cmp("count", int'(cpu_rdata), m_cnt);
    else cmp("mode_reg", int'(cpu_rdata),
             (int'(m_set) << 7) | (int'(m_in) << 6) | (int'(m_out) << 5) | m_mode);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xact(input logic [1:0] p, input bit tgood, input bit egood,
                      input logic [CW-1:0] c);
    @(negedge clk); tok_stb = 1'b1; tok_pid = p; tok_ok = tgood;
    @(negedge clk); tok_stb = 1'b0;
    if (p != 2'b10) begin dat_stb = 1'b1; @(negedge clk); dat_stb = 1'b0; end
    end_stb = 1'b1; end_ok = egood; end_cnt = c;
    @(negedge clk); end_stb = 1'b0; end_ok = 1'b0;
    idle(2);
  endtask

  task automatic cpu_write(input bit s, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0; cpu_sel = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk); cpu_rd = 1'b1; cpu_sel = 1'b0;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic peek_cnt();
    @(negedge clk); cpu_sel = 1'b1;
    @(negedge clk); cpu_sel = 1'b0;
  endtask

  localparam logic [1:0] OUT = 2'b01, IN = 2'b10, SETUP = 2'b11;

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2); peek_cnt();

    cur_req = "R2";
    xact(SETUP, 1, 1, 6'd5); xact(OUT, 1, 1, 6'd5);
    cfg_dir_in = 1'b1; xact(IN, 1, 1, 6'd0); cfg_dir_in = 1'b0;

    cur_req = "R3";
    cpu_write(0, 8'h02);
    xact(IN, 1, 1, 6'd0);            // R4: direction mismatch and setup-only mode
    xact(OUT, 1, 1, 6'd3);           // setup-only ignores OUT
    xact(SETUP, 1, 1, 6'd8);         // ACK, mode 0001, setup bit, lock
    cur_req = "R11"; peek_cnt();

    cur_req = "R8";
    cpu_write(0, 8'h89); cpu_write(1, 8'h11); peek_cnt();
    cur_req = "R9";
    cpu_write(0, 8'h00);             // setup bit cleared while locked
    xact(SETUP, 1, 1, 6'd8);         // setup bit set again while locked
    cur_req = "R8"; cpu_read();

    cur_req = "R4";
    xact(OUT, 1, 1, 6'd2);           // mode 0001 NAKs OUT
    cfg_dir_in = 1'b1; xact(IN, 1, 1, 6'd0); cfg_dir_in = 1'b0;

    cur_req = "R5";
    cpu_write(0, 8'h09);
    xact(OUT, 1, 1, 6'd17);          // ACK, mode 1000
    cur_req = "R10"; cpu_read(); peek_cnt();
    cur_req = "R4"; xact(OUT, 1, 1, 6'd4);
    cur_req = "R5";
    cpu_write(0, 8'h0A); xact(OUT, 1, 1, 6'd9); cpu_read(); xact(OUT, 1, 1, 6'd10);
    cpu_read();

    cfg_dir_in = 1'b1;
    cpu_write(0, 8'h0D); xact(IN, 1, 1, 6'd33);
    cur_req = "R11"; peek_cnt(); cpu_read();
    cur_req = "R4"; xact(IN, 1, 1, 6'd0); xact(OUT, 1, 1, 6'd1);
    cur_req = "R5"; cpu_write(0, 8'h0E); xact(IN, 1, 1, 6'd0); cpu_read();

    cur_req = "R3";
    cpu_write(0, 8'h03); xact(IN, 1, 1, 6'd0); xact(SETUP, 1, 1, 6'd2);
    cfg_dir_in = 1'b0; xact(OUT, 1, 1, 6'd2);

    cur_req = "R6";
    cpu_write(0, 8'h09);
    xact(OUT, 0, 1, 6'd7); xact(OUT, 1, 0, 6'd7);
    @(negedge clk); end_stb = 1'b1; end_ok = 1'b1; @(negedge clk); end_stb = 1'b0; end_ok = 1'b0;
    idle(2); peek_cnt();

    cur_req = "R12";
    @(negedge clk); tok_stb = 1'b1; tok_pid = OUT; tok_ok = 1'b1;
    @(negedge clk); tok_stb = 1'b0; dat_stb = 1'b1;
    @(negedge clk); dat_stb = 1'b0; end_stb = 1'b1; end_ok = 1'b1; end_cnt = 6'd21;
    cpu_wr = 1'b1; cpu_wdata = 8'h02;
    @(negedge clk); end_stb = 1'b0; end_ok = 1'b0; cpu_wr = 1'b0;
    cur_req = "R7"; idle(2);
    cur_req = "R8";
    @(negedge clk); cpu_rd = 1'b1;   // read clears lock
    @(negedge clk); cpu_rd = 1'b0; cpu_write(0, 8'h0C); idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule